// File: doc/BRIEF.md
# Data Access Translation Checker

This block is the stage that turns one data access into a physical address, or into a single fault. Each cycle it may take a request that carries the virtual address, the access size, the direction, the privilege context and the result of a translation lookaside lookup that was done elsewhere. One cycle later it returns four things: the physical address, an uncacheable flag, a three-bit fault code, and a six-bit memory-status vector that tells the exception handler why the access failed. It also returns six one-cycle event pulses, split into load and store, for hits, misses and access violations. Performance counters outside the block count these pulses.

The checks run in a fixed order, and the first one that fails decides the result. The order is: alignment, physical bypass, canonical address, superpage window, lookup miss, page permissions with the fault-on-read and fault-on-write traps, implemented physical width, and last the uncacheable rewrite. The block does not store translation entries.

Top module: `dxlate_check`

## Requirements
- R1: Alignment is checked before anything else. If any address bit below the access size (2^size_lg bytes) is set, the fault is 1 (alignment). The status vector then holds only bit 0 (store), which is set for stores.
- R2: The effective mode is cur_mode when priv_pc is 0. When priv_pc is 1, the effective mode is alt_mode if use_alt is 1, and kernel (0) if it is not. Modes are 0 kernel, 1 executive, 2 supervisor and 3 user. The permission bit for a mode sits at index = mode.
- R3: An address is non-canonical when bits 63:48 are not all copies of bit 47. Outside physical mode, such an address gives fault 2 (page). Its status sets bit 2 (bad address) and bit 1 (violation), and also bit 0 for stores.
- R4: A superpage address has bits 47:41 equal to 7'h7e. If cur_mode is not kernel, it gives fault 3 (violation) with status bit 1, plus bit 0 for stores. This holds even when the effective mode is kernel.
- R5: A superpage address in kernel cur_mode maps with no lookup. PA bits 39:0 are VA bits 39:0, and PA bits 43:40 are all copies of VA bit 40.
- R6: A lookup miss sets status bit 3, plus bit 0 for stores. The fault is 4 when pt_walk is set and 5 when it is not.
- R7: On a store hit whose write enable is clear for the effective mode, the fault is 2. Its status is bits 0 and 1, plus bit 5 if the entry's fault-on-write bit is set. If the write enable is set and fault-on-write is set, the fault is 2 with status bits 0 and 5. On stores the fault-on-read bit has no effect.
- R8: On a load hit whose read enable is clear, the fault is 3 with status bit 1, plus bit 4 if fault-on-read is set. If the read enable is set and fault-on-read is set, the fault is 2 with status bit 4 only.
- R9: In physical mode, PA = VA. A hit maps to {ppn, va[12:0]}. If any bit at or above 44 is set, the fault is 6 (machine check) with status 0. The PA and the uncacheable flag read 0 whenever the fault is not 0.
- R10: An access that succeeds with PA bit 43 set is marked uncacheable, and its PA bits 42:35 are cleared. When bit 43 is clear, the PA passes unchanged.
- R11: Per access there is at most one pulse. A hit pulse fires on a hit with no permission fault (a later machine check still counts). A miss pulse fires on a miss. A violation pulse fires on R3, R4, R7 and R8 faults. Alignment, physical and superpage accesses that succeed give no pulse.
- R12: Outputs are registered, one cycle after the request. With no request, and during synchronous reset, the outputs are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| va | input | 64 | Virtual address |
| size_lg | input | 2 | log2 of access size in bytes |
| is_write | input | 1 | 1 = store |
| phys_mode | input | 1 | Bypass translation |
| use_alt | input | 1 | Use alt_mode when priv_pc is set |
| pt_walk | input | 1 | Access belongs to a page-table walk |
| priv_pc | input | 1 | PC bit 0 (privileged code) |
| cur_mode | input | 2 | Current mode |
| alt_mode | input | 2 | Alternate mode |
| tlb_hit | input | 1 | Lookup found an entry |
| tlb_ppn | input | 32 | Physical page number of the entry |
| tlb_rd_en | input | 4 | Read enable per mode |
| tlb_wr_en | input | 4 | Write enable per mode |
| tlb_fonr | input | 1 | Fault-on-read bit of the entry |
| tlb_fonw | input | 1 | Fault-on-write bit of the entry |
| out_valid | output | 1 | Result valid |
| out_pa | output | 44 | Physical address |
| out_uncached | output | 1 | Access is uncacheable |
| out_fault | output | 3 | Fault code |
| out_stat | output | 6 | Memory-status vector |
| cnt_rd_hit | output | 1 | Load hit pulse |
| cnt_wr_hit | output | 1 | Store hit pulse |
| cnt_rd_miss | output | 1 | Load miss pulse |
| cnt_wr_miss | output | 1 | Store miss pulse |
| cnt_rd_acv | output | 1 | Load violation pulse |
| cnt_wr_acv | output | 1 | Store violation pulse |

## Verification
The block holds no state beyond its output register. A wrong decision therefore shows up at the ports in the very next cycle, as a wrong fault code, a wrong status bit, a wrong address or a wrong pulse. Because the checks have a fixed priority, the bench sets up overlapping conditions (misaligned and non-canonical, superpage with a privileged PC, physical mode with high bits set) and checks that only the earlier check reports. An event pulse that is stuck or duplicated is caught on the idle cycle after a request, when all six pulses must be low.

// File: rtl/dxlate_pkg.sv
package dxlate_pkg;

  typedef enum logic [2:0] {
    FLT_NONE      = 3'd0,
    FLT_ALIGN     = 3'd1,
    FLT_PAGE      = 3'd2,
    FLT_ACV       = 3'd3,
    FLT_MISS_WALK = 3'd4,
    FLT_MISS_NORM = 3'd5,
    FLT_MCHK      = 3'd6
  } fault_e;

  localparam int ST_W     = 6;
  localparam int ST_WR    = 0;
  localparam int ST_ACV   = 1;
  localparam int ST_BADVA = 2;
  localparam int ST_MISS  = 3;
  localparam int ST_FONR  = 4;
  localparam int ST_FONW  = 5;

  localparam int MODE_W    = 2;
  localparam int NUM_MODES = 1 << MODE_W;
  localparam logic [MODE_W-1:0] MODE_KERN = '0;

  typedef struct packed {
    logic rd_hit;
    logic wr_hit;
    logic rd_miss;
    logic wr_miss;
    logic rd_acv;
    logic wr_acv;
  } strobe_t;

endpackage

// File: rtl/dxlate_mode_sel.sv
module dxlate_mode_sel
  import dxlate_pkg::*;
(
  input  logic              priv_pc,
  input  logic              use_alt,
  input  logic [MODE_W-1:0] cur_mode,
  input  logic [MODE_W-1:0] alt_mode,
  output logic [MODE_W-1:0] eff_mode
);
  // Privileged code runs as kernel unless the access explicitly asks for
  // the alternate mode.
  always_comb begin
    if (priv_pc) eff_mode = use_alt ? alt_mode : MODE_KERN;
    else         eff_mode = cur_mode;
  end
endmodule

// File: rtl/dxlate_perm.sv
module dxlate_perm
  import dxlate_pkg::*;
(
  input  logic                 is_write,
  input  logic [MODE_W-1:0]    eff_mode,
  input  logic [NUM_MODES-1:0] rd_en,
  input  logic [NUM_MODES-1:0] wr_en,
  input  logic                 fonr,
  input  logic                 fonw,
  output logic                 viol,
  output logic [2:0]           flt,
  output logic [ST_W-1:0]      stat
);
  logic rd_ok, wr_ok;

  always_comb begin
    rd_ok = 1'b0;
    wr_ok = 1'b0;
    for (int m = 0; m < NUM_MODES; m++) begin
      if (eff_mode == MODE_W'(m)) begin
        rd_ok = rd_en[m];
        wr_ok = wr_en[m];
      end
    end
  end

  always_comb begin
    flt  = FLT_NONE;
    stat = '0;
    if (is_write) begin
      if (!wr_ok) begin
        flt           = FLT_PAGE;
        stat[ST_WR]   = 1'b1;
        stat[ST_ACV]  = 1'b1;
        stat[ST_FONW] = fonw;
      end else if (fonw) begin
        flt           = FLT_PAGE;
        stat[ST_WR]   = 1'b1;
        stat[ST_FONW] = 1'b1;
      end
    end else begin
      if (!rd_ok) begin
        flt           = FLT_ACV;
        stat[ST_ACV]  = 1'b1;
        stat[ST_FONR] = fonr;
      end else if (fonr) begin
        flt           = FLT_PAGE;
        stat[ST_FONR] = 1'b1;
      end
    end
    viol = (flt != FLT_NONE);
  end
endmodule

// File: rtl/dxlate_pa_fix.sv
module dxlate_pa_fix #(
  parameter int RAW_W  = 64,
  parameter int PA_W   = 44,
  parameter int CLR_HI = 42,
  parameter int CLR_LO = 35
) (
  input  logic [RAW_W-1:0] raw_pa,
  output logic             mchk,
  output logic [PA_W-1:0]  pa,
  output logic             uncached
);
  localparam int UC_BIT = PA_W - 1;
  localparam logic [PA_W-1:0] CLR_MASK =
    (PA_W'(1) << (CLR_HI + 1)) - (PA_W'(1) << CLR_LO);

  generate
    if (RAW_W > PA_W) begin : g_wide
      assign mchk = |raw_pa[RAW_W-1:PA_W];
    end else begin : g_narrow
      assign mchk = 1'b0;
    end
  endgenerate

  logic [PA_W-1:0] low_pa;
  assign low_pa = raw_pa[PA_W-1:0];

  always_comb begin
    uncached = low_pa[UC_BIT];
    pa       = uncached ? (low_pa & ~CLR_MASK) : low_pa;
  end
endmodule

// File: rtl/dxlate_check.sv
module dxlate_check
  import dxlate_pkg::*;
#(
  parameter int VA_W     = 64,
  parameter int PA_W     = 44,
  parameter int PPN_W    = 32,
  parameter int PAGE_SH  = 13,
  parameter int SZ_W     = 2,
  parameter int SIGN_BIT = 47,
  parameter int SP_HI    = 47,
  parameter int SP_LO    = 41,
  parameter int SP_TAG   = 'h7e,
  parameter int SPX_BIT  = 40,
  parameter int CLR_HI   = 42,
  parameter int CLR_LO   = 35
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic [VA_W-1:0]      va,
  input  logic [SZ_W-1:0]      size_lg,
  input  logic                 is_write,
  input  logic                 phys_mode,
  input  logic                 use_alt,
  input  logic                 pt_walk,
  input  logic                 priv_pc,
  input  logic [MODE_W-1:0]    cur_mode,
  input  logic [MODE_W-1:0]    alt_mode,
  input  logic                 tlb_hit,
  input  logic [PPN_W-1:0]     tlb_ppn,
  input  logic [NUM_MODES-1:0] tlb_rd_en,
  input  logic [NUM_MODES-1:0] tlb_wr_en,
  input  logic                 tlb_fonr,
  input  logic                 tlb_fonw,
  output logic                 out_valid,
  output logic [PA_W-1:0]      out_pa,
  output logic                 out_uncached,
  output logic [2:0]           out_fault,
  output logic [ST_W-1:0]      out_stat,
  output logic                 cnt_rd_hit,
  output logic                 cnt_wr_hit,
  output logic                 cnt_rd_miss,
  output logic                 cnt_wr_miss,
  output logic                 cnt_rd_acv,
  output logic                 cnt_wr_acv
);
  localparam int ALN_W = (1 << SZ_W) - 1;
  localparam int SP_W  = SP_HI - SP_LO + 1;
  localparam logic [SP_W-1:0] SP_VAL = SP_W'(SP_TAG);

  // ---------------- decode of the address ----------------
  logic [ALN_W-1:0] aln_mask;
  logic             misalign, va_canon, in_sp;

  always_comb begin
    for (int i = 0; i < ALN_W; i++) aln_mask[i] = (i < int'(size_lg));
  end

  assign misalign = |(va[ALN_W-1:0] & aln_mask);
  assign va_canon = (&va[VA_W-1:SIGN_BIT]) | ~(|va[VA_W-1:SIGN_BIT]);
  assign in_sp    = (va[SP_HI:SP_LO] == SP_VAL);

  logic [VA_W-1:0] sp_raw, tlb_raw;

  always_comb begin
    sp_raw                = '0;
    sp_raw[SPX_BIT-1:0]   = va[SPX_BIT-1:0];
    sp_raw[PA_W-1:SPX_BIT] = {(PA_W-SPX_BIT){va[SPX_BIT]}};
    tlb_raw               = '0;
    tlb_raw[PAGE_SH-1:0]  = va[PAGE_SH-1:0];
    tlb_raw[PAGE_SH +: PPN_W] = tlb_ppn;
  end

  // ---------------- sub-blocks ----------------
  logic [MODE_W-1:0] eff_mode;

  dxlate_mode_sel u_mode (
    .priv_pc  (priv_pc),
    .use_alt  (use_alt),
    .cur_mode (cur_mode),
    .alt_mode (alt_mode),
    .eff_mode (eff_mode)
  );

  logic            perm_viol;
  logic [2:0]      perm_flt;
  logic [ST_W-1:0] perm_st;

  dxlate_perm u_perm (
    .is_write (is_write),
    .eff_mode (eff_mode),
    .rd_en    (tlb_rd_en),
    .wr_en    (tlb_wr_en),
    .fonr     (tlb_fonr),
    .fonw     (tlb_fonw),
    .viol     (perm_viol),
    .flt      (perm_flt),
    .stat     (perm_st)
  );

  logic [VA_W-1:0] raw_pa;
  logic            fix_mchk, fix_uc;
  logic [PA_W-1:0] fix_pa;

  dxlate_pa_fix #(
    .RAW_W  (VA_W),
    .PA_W   (PA_W),
    .CLR_HI (CLR_HI),
    .CLR_LO (CLR_LO)
  ) u_pafix (
    .raw_pa   (raw_pa),
    .mchk     (fix_mchk),
    .pa       (fix_pa),
    .uncached (fix_uc)
  );

  // ---------------- priority chain ----------------
  logic [2:0]      pre_flt;
  logic [ST_W-1:0] pre_st;
  logic            pa_live;
  strobe_t         nxt_strb;

  always_comb begin
    pre_flt  = FLT_NONE;
    pre_st   = '0;
    nxt_strb = '0;
    raw_pa   = va;
    pa_live  = 1'b0;
    if (misalign) begin
      pre_flt        = FLT_ALIGN;
      pre_st[ST_WR]  = is_write;
    end else if (phys_mode) begin
      pa_live = 1'b1;
    end else if (!va_canon) begin
      pre_flt          = FLT_PAGE;
      pre_st[ST_WR]    = is_write;
      pre_st[ST_ACV]   = 1'b1;
      pre_st[ST_BADVA] = 1'b1;
      nxt_strb.rd_acv  = !is_write;
      nxt_strb.wr_acv  = is_write;
    end else if (in_sp) begin
      // the superpage gate looks at the current mode, not the effective one
      if (cur_mode != MODE_KERN) begin
        pre_flt         = FLT_ACV;
        pre_st[ST_WR]   = is_write;
        pre_st[ST_ACV]  = 1'b1;
        nxt_strb.rd_acv = !is_write;
        nxt_strb.wr_acv = is_write;
      end else begin
        raw_pa  = sp_raw;
        pa_live = 1'b1;
      end
    end else if (!tlb_hit) begin
      pre_flt          = pt_walk ? FLT_MISS_WALK : FLT_MISS_NORM;
      pre_st[ST_WR]    = is_write;
      pre_st[ST_MISS]  = 1'b1;
      nxt_strb.rd_miss = !is_write;
      nxt_strb.wr_miss = is_write;
    end else begin
      raw_pa = tlb_raw;
      if (perm_viol) begin
        pre_flt         = perm_flt;
        pre_st          = perm_st;
        nxt_strb.rd_acv = !is_write;
        nxt_strb.wr_acv = is_write;
      end else begin
        nxt_strb.rd_hit = !is_write;
        nxt_strb.wr_hit = is_write;
        pa_live         = 1'b1;
      end
    end
  end

  logic [2:0]      nxt_flt;
  logic [PA_W-1:0] nxt_pa;
  logic            nxt_uc;

  always_comb begin
    nxt_flt = pre_flt;
    nxt_pa  = '0;
    nxt_uc  = 1'b0;
    if (pa_live) begin
      if (fix_mchk) begin
        nxt_flt = FLT_MCHK;
      end else begin
        nxt_pa = fix_pa;
        nxt_uc = fix_uc;
      end
    end
  end

  // ---------------- output register ----------------
  strobe_t strb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_pa       <= '0;
      out_uncached <= 1'b0;
      out_fault    <= FLT_NONE;
      out_stat     <= '0;
      strb_q       <= '0;
    end else begin
      out_valid    <= req_valid;
      out_pa       <= req_valid ? nxt_pa  : '0;
      out_uncached <= req_valid && nxt_uc;
      out_fault    <= req_valid ? nxt_flt : FLT_NONE;
      out_stat     <= req_valid ? pre_st  : '0;
      strb_q       <= req_valid ? nxt_strb : '0;
    end
  end

  assign cnt_rd_hit  = strb_q.rd_hit;
  assign cnt_wr_hit  = strb_q.wr_hit;
  assign cnt_rd_miss = strb_q.rd_miss;
  assign cnt_wr_miss = strb_q.wr_miss;
  assign cnt_rd_acv  = strb_q.rd_acv;
  assign cnt_wr_acv  = strb_q.wr_acv;
endmodule

// File: rtl/dxlate_check_sva.sv
module dxlate_check_sva
  import dxlate_pkg::*;
#(
  parameter int PA_W   = 44,
  parameter int CLR_HI = 42,
  parameter int CLR_LO = 35
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            out_valid,
  input logic [PA_W-1:0] out_pa,
  input logic            out_uncached,
  input logic [2:0]      out_fault,
  input logic [ST_W-1:0] out_stat,
  input logic [5:0]      strobes
);
  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!out_valid && out_fault == FLT_NONE && strobes == 6'd0));

  assert_single_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strobes));

  assert_no_pulse_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> strobes == 6'd0);

  assert_align_stat_R1: assert property (@(posedge clk) disable iff (rst)
    out_fault == FLT_ALIGN |-> ((out_stat & ~(ST_W'(1) << ST_WR)) == '0 && strobes == 6'd0));

  assert_miss_stat_R6: assert property (@(posedge clk) disable iff (rst)
    (out_fault == FLT_MISS_WALK || out_fault == FLT_MISS_NORM) |-> out_stat[ST_MISS]);

  assert_acv_stat_R4: assert property (@(posedge clk) disable iff (rst)
    out_fault == FLT_ACV |-> out_stat[ST_ACV]);

  assert_mchk_clean_R9: assert property (@(posedge clk) disable iff (rst)
    out_fault == FLT_MCHK |-> (out_stat == '0 && !out_uncached && out_pa == '0));

  assert_uc_clear_R10: assert property (@(posedge clk) disable iff (rst)
    out_uncached |-> (out_pa[PA_W-1] && out_pa[CLR_HI:CLR_LO] == '0 && out_fault == FLT_NONE));

  assert_ok_nostat_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_fault == FLT_NONE) |-> out_stat == '0);
endmodule

bind dxlate_check dxlate_check_sva #(
  .PA_W   (PA_W),
  .CLR_HI (CLR_HI),
  .CLR_LO (CLR_LO)
) u_sva (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .out_valid    (out_valid),
  .out_pa       (out_pa),
  .out_uncached (out_uncached),
  .out_fault    (out_fault),
  .out_stat     (out_stat),
  .strobes      ({cnt_rd_hit, cnt_wr_hit, cnt_rd_miss, cnt_wr_miss, cnt_rd_acv, cnt_wr_acv})
);

// File: tb/dxlate_check_bench.sv
module dxlate_check_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [63:0] va = '0;
  logic [1:0]  size_lg = '0;
  logic        is_write = 1'b0, phys_mode = 1'b0, use_alt = 1'b0, pt_walk = 1'b0, priv_pc = 1'b0;
  logic [1:0]  cur_mode = '0, alt_mode = '0;
  logic        tlb_hit = 1'b0;
  logic [31:0] tlb_ppn = '0;
  logic [3:0]  tlb_rd_en = '0, tlb_wr_en = '0;
  logic        tlb_fonr = 1'b0, tlb_fonw = 1'b0;
  logic        out_valid, out_uncached;
  logic [43:0] out_pa;
  logic [2:0]  out_fault;
  logic [5:0]  out_stat;
  logic        cnt_rd_hit, cnt_wr_hit, cnt_rd_miss, cnt_wr_miss, cnt_rd_acv, cnt_wr_acv;

  always #2 clk = ~clk;

  dxlate_check u_dxlate_check (
    .clk(clk), .rst(rst), .req_valid(req_valid), .va(va), .size_lg(size_lg),
    .is_write(is_write), .phys_mode(phys_mode), .use_alt(use_alt), .pt_walk(pt_walk),
    .priv_pc(priv_pc), .cur_mode(cur_mode), .alt_mode(alt_mode), .tlb_hit(tlb_hit),
    .tlb_ppn(tlb_ppn), .tlb_rd_en(tlb_rd_en), .tlb_wr_en(tlb_wr_en),
    .tlb_fonr(tlb_fonr), .tlb_fonw(tlb_fonw), .out_valid(out_valid), .out_pa(out_pa),
    .out_uncached(out_uncached), .out_fault(out_fault), .out_stat(out_stat),
    .cnt_rd_hit(cnt_rd_hit), .cnt_wr_hit(cnt_wr_hit), .cnt_rd_miss(cnt_rd_miss),
    .cnt_wr_miss(cnt_wr_miss), .cnt_rd_acv(cnt_rd_acv), .cnt_wr_acv(cnt_wr_acv)
  );

  wire [5:0] strb = {cnt_rd_hit, cnt_wr_hit, cnt_rd_miss, cnt_wr_miss, cnt_rd_acv, cnt_wr_acv};

  typedef struct packed {
    logic [63:0] va;
    logic [1:0]  sz;
    logic        wr, ph, alt, walk, priv;
    logic [1:0]  cur, altm;
    logic        hit;
    logic [31:0] ppn;
    logic [3:0]  rd, wn;
    logic        fonr, fonw;
    logic [2:0]  e_flt;
    logic [5:0]  e_st;
    logic [43:0] e_pa;
    logic        e_uc;
    logic [5:0]  e_strb;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 29;
  // strobe order: rd_hit wr_hit rd_miss wr_miss rd_acv wr_acv
  localparam vec_t TBL [NV] = '{
    '{64'h123458, 2'd3, 1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0,2'd0, 1'b1, 32'h55, 4'hF,4'hF, 1'b0,1'b0, 3'd0, 6'h00, 44'hAB458, 1'b0, 6'b100000, 4'd8},  // R8 load hit
    '{64'h123458, 2'd3, 1'b1,1'b0,1'b0,1'b0,1'b0, 2'd0,2'd0, 1'b1, 32'h55, 4'hF,4'hF, 1'b0,1'b0, 3'd0, 6'h00, 44'hAB458, 1'b0, 6'b010000, 4'd7},  // R7 store hit
    '{64'h12345A, 2'd2, 1'b1,1'b0,1'b0,1'b0,1'b0, 2'd0,2'd0, 1'b1, 32'h55, 4'hF,4'hF, 1'b0,1'b0, 3'd1, 6'h01, 44'h0, 1'b0, 6'b000000, 4'd1},     // R1 store misaligned
    '{64'h123459, 2'd1, 1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0,2'd0, 1'b1, 32'h55, 4'hF,4'hF, 1'b0,1'b0, 3'd1, 6'h00, 44'h0, 1'b0, 6'b000000, 4'd1},     // R1 load misaligned
    '{64'h123459, 2'd0, 1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0,2'd0, 1'b1, 32'h55, 4'hF,4'hF, 1'b0,1'b0, 3'd0, 6'h00, 44'hAB459, 1'b0, 6'b100000, 4'd1}, // R1 byte ok
    '{64'h0001000000000004, 2'd3, 1'b1,1'b0,1'b0,1'b0,1'b0, 2'd0,2'd0, 1'b1, 32'h55, 4'hF,4'hF, 1'b0,1'b0, 3'd1, 6'h01, 44'h0, 1'b0, 6'b000000, 4'd1}, // R1 over R3
    '{64'h0001000000000000, 2'd3, 1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0,2'd0, 1'b1, 32'h55, 4'hF,4'hF, 1'b0,1'b0, 3'd2, 6'h06, 44'h0, 1'b0, 6'b000010, 4'd3}, // R3 load
    '{64'hFFFF000000000000, 2'd3, 1'b1,1'b0,1'b0,1'b0,1'b0, 2'd0,2'd0, 1'b1, 32'h55, 4'hF,4'hF, 1'b0,1'b0, 3'd2, 6'h07, 44'h0, 1'b0, 6'b000001, 4'd3}, // R3 store
    '{64'hFFFFFC0000012340, 2'd3, 1'b1,1'b0,1'b0,1'b0,1'b0, 2'd3,2'd0, 1'b1, 32'h55, 4'hF,4'hF, 1'b0,1'b0, 3'd3, 6'h03, 44'h0, 1'b0, 6'b000001, 4'd4}, // R4 user store
    '{64'hFFFFFC0000012340, 2'd3, 1'b0,1'b0,1'b0,1'b0,1'b1, 2'd3,2'd0, 1'b1, 32'h55, 4'hF,4'hF, 1'b0,1'b0, 3'd3, 6'h02, 44'h0, 1'b0, 6'b000010, 4'd4}, // R4 priv pc, cur user
    '{64'hFFFFFCF800012340, 2'd3, 1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0,2'd0, 1'b0, 32'h55, 4'hF,4'hF, 1'b0,1'b0, 3'd0, 6'h00, 44'h0F800012340, 1'b0, 6'b000000, 4'd5}, // R5 cacheable
    '{64'hFFFFFDF800012340, 2'd3, 1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0,2'd0, 1'b0, 32'h55, 4'hF,4'hF, 1'b0,1'b0, 3'd0, 6'h00, 44'h80000012340, 1'b1, 6'b000000, 4'd5}, // R5 bit40 ext
    '{64'h123458, 2'd3, 1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0,2'd0, 1'b0, 32'h55, 4'hF,4'hF, 1'b0,1'b0, 3'd5, 6'h08, 44'h0, 1'b0, 6'b001000, 4'd6},  // R6 normal miss
    '{64'h123458, 2'd3, 1'b1,1'b0,1'b0,1'b1,1'b0, 2'd0,2'd0, 1'b0, 32'h55, 4'hF,4'hF, 1'b0,1'b0, 3'd4, 6'h09, 44'h0, 1'b0, 6'b000100, 4'd6},  // R6 walk miss store
    '{64'h123458, 2'd3, 1'b1,1'b0,1'b0,1'b0,1'b0, 2'd3,2'd0, 1'b1, 32'h55, 4'hF,4'h7, 1'b0,1'b1, 3'd2, 6'h23, 44'h0, 1'b0, 6'b000001, 4'd7},  // R7 no wr + fonw
    '{64'h123458, 2'd3, 1'b1,1'b0,1'b0,1'b0,1'b0, 2'd3,2'd0, 1'b1, 32'h55, 4'hF,4'hF, 1'b0,1'b1, 3'd2, 6'h21, 44'h0, 1'b0, 6'b000001, 4'd7},  // R7 fonw only
    '{64'h123458, 2'd3, 1'b1,1'b0,1'b0,1'b0,1'b0, 2'd3,2'd0, 1'b1, 32'h55, 4'hF,4'h7, 1'b0,1'b0, 3'd2, 6'h03, 44'h0, 1'b0, 6'b000001, 4'd7},  // R7 no wr
    '{64'h123458, 2'd3, 1'b0,1'b0,1'b0,1'b0,1'b0, 2'd2,2'd0, 1'b1, 32'h55, 4'hB,4'hF, 1'b1,1'b0, 3'd3, 6'h12, 44'h0, 1'b0, 6'b000010, 4'd8},  // R8 no rd + fonr
    '{64'h123458, 2'd3, 1'b0,1'b0,1'b0,1'b0,1'b0, 2'd2,2'd0, 1'b1, 32'h55, 4'hF,4'hF, 1'b1,1'b0, 3'd2, 6'h10, 44'h0, 1'b0, 6'b000010, 4'd8},  // R8 fonr only
    '{64'h123458, 2'd3, 1'b1,1'b0,1'b0,1'b0,1'b0, 2'd2,2'd0, 1'b1, 32'h55, 4'hF,4'hF, 1'b1,1'b0, 3'd0, 6'h00, 44'hAB458, 1'b0, 6'b010000, 4'd7}, // R7 fonr ignored on store
    '{64'h123458, 2'd3, 1'b0,1'b0,1'b1,1'b0,1'b1, 2'd0,2'd1, 1'b1, 32'h55, 4'hD,4'hF, 1'b0,1'b0, 3'd3, 6'h02, 44'h0, 1'b0, 6'b000010, 4'd2},  // R2 alt mode used
    '{64'h123458, 2'd3, 1'b0,1'b0,1'b0,1'b0,1'b1, 2'd3,2'd0, 1'b1, 32'h55, 4'h1,4'hF, 1'b0,1'b0, 3'd0, 6'h00, 44'hAB458, 1'b0, 6'b100000, 4'd2}, // R2 priv -> kernel
    '{64'h123458, 2'd3, 1'b0,1'b0,1'b1,1'b0,1'b0, 2'd3,2'd0, 1'b1, 32'h55, 4'h1,4'hF, 1'b0,1'b0, 3'd3, 6'h02, 44'h0, 1'b0, 6'b000010, 4'd2},  // R2 alt ignored w/o priv
    '{64'h12345678, 2'd3, 1'b0,1'b1,1'b0,1'b0,1'b0, 2'd0,2'd0, 1'b0, 32'h55, 4'hF,4'hF, 1'b0,1'b0, 3'd0, 6'h00, 44'h12345678, 1'b0, 6'b000000, 4'd9}, // R9 phys
    '{64'h0000100000000000, 2'd3, 1'b0,1'b1,1'b0,1'b0,1'b0, 2'd0,2'd0, 1'b0, 32'h55, 4'hF,4'hF, 1'b0,1'b0, 3'd6, 6'h00, 44'h0, 1'b0, 6'b000000, 4'd9}, // R9 phys mchk
    '{64'h123458, 2'd3, 1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0,2'd0, 1'b1, 32'h80000000, 4'hF,4'hF, 1'b0,1'b0, 3'd6, 6'h00, 44'h0, 1'b0, 6'b100000, 4'd9}, // R9 tlb mchk
    '{64'h123458, 2'd3, 1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0,2'd0, 1'b1, 32'h7FC00000, 4'hF,4'hF, 1'b0,1'b0, 3'd0, 6'h00, 44'h80000001458, 1'b1, 6'b100000, 4'd10}, // R10 tlb uc
    '{64'h00000FFFFFFFFFF8, 2'd3, 1'b1,1'b1,1'b0,1'b0,1'b0, 2'd0,2'd0, 1'b0, 32'h55, 4'hF,4'hF, 1'b0,1'b0, 3'd0, 6'h00, 44'h807FFFFFFF8, 1'b1, 6'b000000, 4'd10}, // R10 phys uc
    '{64'h0001000000000000, 2'd3, 1'b0,1'b1,1'b0,1'b0,1'b0, 2'd0,2'd0, 1'b0, 32'h55, 4'hF,4'hF, 1'b0,1'b0, 3'd6, 6'h00, 44'h0, 1'b0, 6'b000000, 4'd9}  // R9 phys skips R3
  };

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    req_valid = 1'b1;
    va = v.va; size_lg = v.sz; is_write = v.wr; phys_mode = v.ph; use_alt = v.alt;
    pt_walk = v.walk; priv_pc = v.priv; cur_mode = v.cur; alt_mode = v.altm;
    tlb_hit = v.hit; tlb_ppn = v.ppn; tlb_rd_en = v.rd; tlb_wr_en = v.wn;
    tlb_fonr = v.fonr; tlb_fonw = v.fonw;
  endtask

  task automatic check_vec(input vec_t v, input int idx);
    logic [63:0] act, exp;
    act = {4'h0, out_valid, out_fault, out_stat, out_uncached, out_pa, strb};
    exp = {4'h0, 1'b1, v.e_flt, v.e_st, v.e_uc, v.e_pa, v.e_strb};
    chk(act == exp, $sformatf("R%0d vector %0d", v.rq, idx), act, exp);
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk({out_valid, out_fault, out_stat, out_pa, out_uncached, strb} == '0, "R12 reset state",
        {out_valid, out_fault, out_stat, out_uncached, strb}, 64'h0);
    rst = 1'b0;
    @(negedge clk);
    drive(TBL[0]);
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      check_vec(TBL[i], i);
      if (i + 1 < NV) drive(TBL[i+1]);
      else begin
        req_valid = 1'b0;
        tlb_hit = 1'b0; phys_mode = 1'b0; va = 64'h123458; size_lg = 2'd3;
      end
    end
    // R11 / R12: idle cycle with a would-be miss on the inputs gives no pulse
    @(negedge clk);
    chk(!out_valid && strb == 6'd0 && out_fault == 3'd0, "R11 idle no pulse", {out_valid, strb}, 64'h0);
    // R12 latency: request presented, outputs unchanged before the edge
    is_write = 1'b1;
    req_valid = 1'b1;
    #1;
    chk(!out_valid && strb == 6'd0, "R12 not before edge", {out_valid, strb}, 64'h0);
    @(negedge clk);
    chk(out_valid && out_fault == 3'd5 && out_stat == 6'h09 && strb == 6'b000100,
        "R6 store miss after one cycle", {out_valid, out_fault, out_stat, strb}, {1'b1, 3'd5, 6'h09, 6'b000100});
    req_valid = 1'b0;
    @(negedge clk);
    chk(strb == 6'd0, "R11 pulse lasts one cycle", strb, 64'h0);
    // R12 reset while a request is held
    req_valid = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    chk(!out_valid && strb == 6'd0 && out_stat == 6'd0, "R12 reset overrides request",
        {out_valid, out_stat, strb}, 64'h0);
    rst = 1'b0;
    req_valid = 1'b0;
    @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule